// File: doc/BRIEF.md
# Power-On Strap Latch Sequencer

This block lets a set of shared pins serve two purposes. While the supply comes up, the pins act as configuration inputs whose levels come from external pull resistors. Once the supply is valid, the pins carry clocks. After the power-good input rises, the sequencer keeps every shared pin's output driver off for a fixed number of reference-clock cycles. During that window the resistors settle the pin levels. On the last cycle of the window it captures each pin's level. In that same cycle it turns on the output drivers and raises a ready flag.

Each pin level passes through a multi-flop synchroniser, and the synchronised value is the one captured. Other logic then uses the captured bits to pick an operating frequency and the role of a dual-function pin. That decoding lives outside this block. The captured bits do not change until power-good falls. A falling power-good returns everything to the reset state, and the next rising edge starts a fresh window.

Top module: `strap_capture_seq`

## Requirements
- R1: While `pwr_good` is low, `strap_bits`, `pin_oe` and `ready` are all zero.
- R2: For the first `WINDOW_CYCLES`-1 rising clock edges after `pwr_good` rises, `pin_oe` stays all-zero and `ready` stays low.
- R3: `ready` becomes 1 on exactly the `WINDOW_CYCLES`-th rising edge after `pwr_good` rises.
- R4: On that edge, bit i of `strap_bits` is 1 when `pin_in[i]` was high and 0 when it was low, for a pin held steady since before the window.
- R5: `pin_oe` is all ones whenever `ready` is 1 and all zeros whenever `ready` is 0.
- R6: Once `ready` is high, changes on `pin_in` have no effect on `strap_bits`.
- R7: Once `ready` is high, it stays high for as long as `pwr_good` stays high.
- R8: When `pwr_good` falls and rises again, a new full window runs and the new pin levels are captured.
- R9: The captured value is the output of a `SYNC_STAGES`-flop synchroniser. A pin change applied after edge `WINDOW_CYCLES`-`SYNC_STAGES` is not captured. A change applied one edge earlier is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_good | input | 1 | Supply-valid indication; low acts as an asynchronous reset |
| pin_in | input | NUM_PINS | Level seen on each shared pin |
| strap_bits | output | NUM_PINS | Captured configuration bits |
| pin_oe | output | NUM_PINS | Output-driver enable for each shared pin |
| ready | output | 1 | High once the bits are captured and the drivers are on |

## Verification
Every result is due at a fixed edge count after `pwr_good` rises. `ready`, `pin_oe` and `strap_bits` all change on edge `WINDOW_CYCLES`. A pin change reaches the capture register after `SYNC_STAGES` edges. The bench drives inputs on falling edges. It counts rising edges from the release of `pwr_good` and samples on the falling edge that follows the edge of interest. It samples both one edge before and on the edge a result is due. For the synchroniser boundary, it applies pin changes on both sides of the cutoff edge.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

   typedef enum logic [0:0] {
      SEQ_WINDOW = 1'b0,
      SEQ_LIVE   = 1'b1
   } seq_state_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < int'(STAGES); s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/window_timer.sv
module window_timer
   import strap_seq_pkg::*;
#(
   parameter int unsigned LENGTH = 28636
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);

   localparam int unsigned CW = cnt_width(LENGTH);
   localparam logic [CW-1:0] LAST_VAL = CW'(LENGTH - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (run && !last)        cnt_q <= cnt_q + 1'b1;
   end

   assign last = run && (cnt_q == LAST_VAL);

endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
   parameter int unsigned WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [WIDTH-1:0] sync_lvl,
   output logic [WIDTH-1:0] bits_q,
   output logic [WIDTH-1:0] oe_q
);

   generate
      for (genvar i = 0; i < int'(WIDTH); i++) begin : g_pin
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bits_q[i] <= 1'b0;
               oe_q[i]   <= 1'b0;
            end else if (capture) begin
               bits_q[i] <= sync_lvl[i];
               oe_q[i]   <= 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/strap_capture_seq.sv
module strap_capture_seq
   import strap_seq_pkg::*;
#(
   parameter int unsigned NUM_PINS      = 5,
   parameter int unsigned WINDOW_CYCLES = 28636,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic                clk,
   input  logic                pwr_good,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] strap_bits,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                ready
);

   generate
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("NUM_PINS must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (WINDOW_CYCLES <= SYNC_STAGES) begin : g_bad_window
         $error("WINDOW_CYCLES must exceed SYNC_STAGES");
      end
   endgenerate

   seq_state_t          state_q;
   logic                win_last;
   logic                capture;
   logic [NUM_PINS-1:0] sync_lvl;

   strap_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (pwr_good),
      .d_in  (pin_in),
      .d_out (sync_lvl)
   );

   window_timer #(
      .LENGTH (WINDOW_CYCLES)
   ) u_timer (
      .clk   (clk),
      .rst_n (pwr_good),
      .run   (state_q == SEQ_WINDOW),
      .last  (win_last)
   );

   assign capture = (state_q == SEQ_WINDOW) && win_last;

   always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good)    state_q <= SEQ_WINDOW;
      else if (capture) state_q <= SEQ_LIVE;
   end

   strap_latch #(
      .WIDTH (NUM_PINS)
   ) u_latch (
      .clk      (clk),
      .rst_n    (pwr_good),
      .capture  (capture),
      .sync_lvl (sync_lvl),
      .bits_q   (strap_bits),
      .oe_q     (pin_oe)
   );

   assign ready = (state_q == SEQ_LIVE);

endmodule

// File: rtl/strap_capture_chk.sv
module strap_capture_chk #(
   parameter int unsigned NUM_PINS      = 5,
   parameter int unsigned WINDOW_CYCLES = 28636
) (
   input logic                clk,
   input logic                pwr_good,
   input logic [NUM_PINS-1:0] pin_in,
   input logic [NUM_PINS-1:0] strap_bits,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                ready
);

   localparam int unsigned CW = $clog2(WINDOW_CYCLES + 1) + 1;
   localparam logic [CW-1:0] WLIM = CW'(WINDOW_CYCLES);

   logic [CW-1:0] edges_q;

   always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good)         edges_q <= '0;
      else if (edges_q < WLIM) edges_q <= edges_q + 1'b1;
   end

   // R1
   always_ff @(posedge clk) begin
      if (!pwr_good) begin
         reset_state_chk: assert (strap_bits == '0 && pin_oe == '0 && !ready);
      end
   end

   // R2 R3
   ready_timing_chk: assert property (@(posedge clk) disable iff (!pwr_good)
      ready == (edges_q >= WLIM));

   // R5
   oe_match_chk: assert property (@(posedge clk) disable iff (!pwr_good)
      pin_oe == (ready ? {NUM_PINS{1'b1}} : {NUM_PINS{1'b0}}));

   // R6
   strap_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
      $past(ready) |-> $stable(strap_bits));

   // R7
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!pwr_good)
      $past(ready) |-> ready);

   // R2
   no_drive_in_window_chk: assert property (@(posedge clk) disable iff (!pwr_good)
      !ready |-> (pin_oe == '0 && strap_bits == '0));

   logic unused_pin;
   assign unused_pin = ^pin_in;

endmodule

bind strap_capture_seq strap_capture_chk #(
   .NUM_PINS      (NUM_PINS),
   .WINDOW_CYCLES (WINDOW_CYCLES)
) u_chk (
   .clk        (clk),
   .pwr_good   (pwr_good),
   .pin_in     (pin_in),
   .strap_bits (strap_bits),
   .pin_oe     (pin_oe),
   .ready      (ready)
);

// File: tb/sim_strap_capture_seq.sv
`timescale 1ns/1ps
module sim_strap_capture_seq;

   localparam int unsigned NP = 5;
   localparam int unsigned WC = 24;
   localparam int unsigned SS = 2;

   logic          clk = 1'b0;
   logic          pwr_good = 1'b1;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] strap_bits;
   logic [NP-1:0] pin_oe;
   logic          ready;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   strap_capture_seq #(
      .NUM_PINS      (NP),
      .WINDOW_CYCLES (WC),
      .SYNC_STAGES   (SS)
   ) u0 (
      .clk        (clk),
      .pwr_good   (pwr_good),
      .pin_in     (pin_in),
      .strap_bits (strap_bits),
      .pin_oe     (pin_oe),
      .ready      (ready)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // drop power, hold pins, release on a falling edge
   task automatic power_up(input logic [NP-1:0] lvl);
      @(negedge clk);
      pwr_good = 1'b0;
      pin_in   = lvl;
      edges(2);
      pwr_good = 1'b1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      pwr_good = 1'b0;
      edges(2);
      check("R1 strap_bits", 32'(strap_bits), 32'h0);
      check("R1 pin_oe", 32'(pin_oe), 32'h0);
      check("R1 ready", 32'(ready), 32'h0);
   endtask

   task automatic t_window(input logic [NP-1:0] lvl);
      power_up(lvl);
      edges(1);
      check("R2 oe early", 32'(pin_oe), 32'h0);
      edges(WC - 2);
      check("R2 ready before last edge", 32'(ready), 32'h0);
      check("R2 oe before last edge", 32'(pin_oe), 32'h0);
      edges(1);
      check("R3 ready on window edge", 32'(ready), 32'h1);
      check("R5 oe with ready", 32'(pin_oe), 32'h1f);
      check("R4 captured bits", 32'(strap_bits), 32'(lvl));
   endtask

   task automatic t_ignore_after;
      logic [NP-1:0] held;
      held = strap_bits;
      pin_in = ~pin_in;
      edges(SS + 3);
      check("R6 bits unchanged", 32'(strap_bits), 32'(held));
      pin_in = 5'h0a;
      edges(40);
      check("R6 bits unchanged late", 32'(strap_bits), 32'(held));
      check("R7 ready held", 32'(ready), 32'h1);
      check("R5 oe held", 32'(pin_oe), 32'h1f);
   endtask

   task automatic t_repower;
      power_up(5'h11);
      edges(WC - 1);
      check("R8 ready low in new window", 32'(ready), 32'h0);
      edges(1);
      check("R8 ready after new window", 32'(ready), 32'h1);
      check("R8 new bits", 32'(strap_bits), 32'h11);
   endtask

   task automatic t_sync_late;
      power_up(5'h00);
      edges(WC - SS);
      pin_in = 5'h1f;
      edges(SS);
      check("R9 late change not captured", 32'(strap_bits), 32'h00);
      check("R9 ready", 32'(ready), 32'h1);
   endtask

   task automatic t_sync_early;
      power_up(5'h00);
      edges(WC - SS - 1);
      pin_in = 5'h1f;
      edges(SS + 1);
      check("R9 early change captured", 32'(strap_bits), 32'h1f);
   endtask

   initial begin
      #1 pwr_good = 1'b0;
      t_reset();
      t_window(5'h15);
      t_ignore_after();
      t_window(5'h0a);
      t_window(5'h1f);
      t_reset();
      t_repower();
      t_sync_late();
      t_sync_early();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #100000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule